// File: doc/BRIEF.md
# Rotating Phase-Shedding Sequencer for a Four-Phase Buck Converter

This block is the digital sequencing logic for an interleaved multiphase step-down converter. It counts a fast reference clock into a switching period of `PERIOD` reference cycles, which is four by default. Within each period it issues a one-cycle set pulse to every enabled phase. The pulses are staggered evenly, so with four phases and a four-cycle period, phases 0 to 3 fire on consecutive reference cycles and sit 90 degrees apart. Each phase also has an enable that keeps its power stage active.

Under heavy load the sequencer runs every phase. When a light-load indication has been held long enough, measured by an 8-bit qualification counter, it moves to pulse-frequency operation. In that mode it drives at most one phase at a time. A burst request comes from the output-voltage window comparator. While the request is high, the phase chosen by a rotation pointer switches. When the request falls, the pointer steps to the next phase and, once the running period completes, every phase is turned off and the period clock is gated. Because the pointer moves after every burst, the switching stress is shared by all phases instead of resting on phase 0.

When the light-load indication drops, the sequencer returns to full-phase operation at once. The rotation pointer is kept across such an excursion and is cleared only by reset.

Top module: `rot_shed_ctrl`

## Requirements
- R1: While `rst_n` is low, `phase_en_o`, `set_pulse_o` and `clk_run_o` are all 0. After reset the rotation pointer selects phase 0 and the mode is full-phase.
- R2: With `light_load_i` low, `phase_en_o` is 4'b1111 and `clk_run_o` is 1 from the first cycle after reset release onward.
- R3: Bit p of `set_pulse_o` belongs to phase p. It is high for exactly one cycle per period, in the cycle whose period slot equals p*PERIOD/NPH, and only while phase p is enabled. With all phases enabled, the pulses appear on bits 0, 1, 2, 3 on consecutive cycles and then repeat.
- R4: Pulse-frequency mode is entered only after `light_load_i` has been sampled high on QUAL_THRESH+1 consecutive clock edges. A run of QUAL_THRESH high samples followed by a low sample leaves all phases enabled.
- R5: In pulse-frequency mode at most one bit of `phase_en_o` is high. While a burst is being served, that bit is the phase selected by the rotation pointer, and no other phase pulses.
- R6: In pulse-frequency mode the pointer steps 0, 1, 2, 3, 0 on each falling edge of `burst_i`. It does not move while `burst_i` stays high, and falling edges of `burst_i` in full-phase mode do not move it.
- R7: After a burst ends in pulse-frequency mode, once the current period has finished, `phase_en_o` is 0, `clk_run_o` is 0 and no set pulse occurs.
- R8: `phase_en_o` changes only at the end of a period (slot PERIOD-1) or while the period clock is stopped, so no enabled phase loses its pulse. A burst held for L edges starting from the stopped state gives exactly ceil(L/PERIOD) pulses on the selected phase.
- R9: When `light_load_i` falls, the mode is full-phase from the next edge on. From the stopped state, `phase_en_o` reads 4'b1111 and `clk_run_o` reads 1 one cycle after the fall.
- R10: The rotation pointer keeps its value through an excursion into full-phase mode. After a reset, the first burst is served by phase 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (period clock source) |
| rst_n | input | 1 | Active-low synchronous reset |
| light_load_i | input | 1 | Light-load indication from the mode detector |
| burst_i | input | 1 | Burst request from the output-voltage window comparator |
| phase_en_o | output | NPH (4) | Per-phase power-stage enables, bit p = phase p |
| set_pulse_o | output | NPH (4) | Per-phase one-cycle set pulses, bit p = phase p |
| clk_run_o | output | 1 | High while the period clock runs; low means clock generation is gated |

## Verification
Full-phase mode is first checked with the light-load input low, to confirm the 1-2-4-8 pulse staircase that separates correct phase staggering from a shared or swapped slot. In pulse-frequency mode a table of bursts with lengths 1, 2, 4, 6, 9 and 13 cycles is played back. Its exact pulse counts per phase show rotation order, single-phase selection and whether a period is cut short, with the 1-cycle and 4-cycle entries at the period edges. Light-load runs one cycle short of the qualification threshold and one cycle past it locate the threshold exactly. A return to full-phase mode with stray burst edges, followed by a further burst and then a reset, shows whether the pointer is held or cleared when it should be.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

    typedef enum logic {
        MODE_FULL  = 1'b0,
        MODE_SHED  = 1'b1
    } mode_e;

endpackage

// File: rtl/rsc_mode_qual.sv
module rsc_mode_qual
    import rsc_pkg::*;
#(
    parameter int QUAL_W      = 8,
    parameter int QUAL_THRESH = 200
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  light_load_i,
    output mode_e mode_nxt_o,
    output mode_e mode_o
);

    localparam logic [QUAL_W-1:0] THR = QUAL_W'(QUAL_THRESH);

    typedef struct packed {
        logic [QUAL_W-1:0] qual;
        mode_e             mode;
    } qual_state_t;

    qual_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!light_load_i) begin
            st_d.qual = '0;
            st_d.mode = MODE_FULL;
        end else begin
            if (st_q.qual != THR) begin
                st_d.qual = st_q.qual + 1'b1;
            end
            if (st_q.qual == THR) begin
                st_d.mode = MODE_SHED;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.qual <= '0;
            st_q.mode <= MODE_FULL;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_nxt_o = st_d.mode;
    assign mode_o     = st_q.mode;

endmodule

// File: rtl/rsc_rotor.sv
module rsc_rotor
    import rsc_pkg::*;
#(
    parameter int NPH   = 4,
    parameter int PTR_W = (NPH > 1) ? $clog2(NPH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  mode_e            mode_i,
    input  logic             burst_i,
    output logic [PTR_W-1:0] ptr_o,
    output logic [NPH-1:0]   sel_oh_o
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(NPH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic             burst_prev;
    } rot_state_t;

    rot_state_t st_d, st_q;
    logic       burst_fell;

    always_comb begin
        st_d            = st_q;
        burst_fell      = st_q.burst_prev && !burst_i;
        st_d.burst_prev = burst_i;
        if (burst_fell && (mode_i == MODE_SHED)) begin
            st_d.ptr = (st_q.ptr == LAST) ? '0 : st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ptr        <= '0;
            st_q.burst_prev <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar p = 0; p < NPH; p++) begin : g_sel
        assign sel_oh_o[p] = (st_q.ptr == PTR_W'(p));
    end

    assign ptr_o = st_q.ptr;

endmodule

// File: rtl/rsc_slot_timer.sv
module rsc_slot_timer #(
    parameter int NPH    = 4,
    parameter int PERIOD = 4,
    parameter int SLOT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPH-1:0]    target_i,
    output logic [NPH-1:0]    en_o,
    output logic [NPH-1:0]    pulse_o,
    output logic              run_o,
    output logic [SLOT_W-1:0] slot_o
);

    localparam int              STEP = PERIOD / NPH;
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(PERIOD - 1);

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [NPH-1:0]    en;
        logic              run;
    } tmr_state_t;

    tmr_state_t st_d, st_q;
    logic       at_edge;

    always_comb begin
        st_d    = st_q;
        at_edge = !st_q.run || (st_q.slot == LAST);
        if (at_edge) begin
            st_d.en = target_i;
        end
        st_d.run = (|target_i) || (|st_d.en);
        if (st_q.run) begin
            st_d.slot = (st_q.slot == LAST) ? '0 : st_q.slot + 1'b1;
        end else begin
            st_d.slot = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.slot <= '0;
            st_q.en   <= '0;
            st_q.run  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar p = 0; p < NPH; p++) begin : g_pulse
        assign pulse_o[p] = st_q.run && st_q.en[p] && (st_q.slot == SLOT_W'(p * STEP));
    end

    assign en_o   = st_q.en;
    assign run_o  = st_q.run;
    assign slot_o = st_q.slot;

endmodule

// File: rtl/rot_shed_ctrl.sv
module rot_shed_ctrl
    import rsc_pkg::*;
#(
    parameter int NPH         = 4,
    parameter int PERIOD      = 4,
    parameter int QUAL_W      = 8,
    parameter int QUAL_THRESH = 200
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           light_load_i,
    input  logic           burst_i,
    output logic [NPH-1:0] phase_en_o,
    output logic [NPH-1:0] set_pulse_o,
    output logic           clk_run_o
);

    localparam int PTR_W  = (NPH > 1) ? $clog2(NPH) : 1;
    localparam int SLOT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;

    mode_e             mode_nxt;
    mode_e             mode_cur;
    logic [PTR_W-1:0]  ptr_w;
    logic [NPH-1:0]    sel_oh;
    logic [NPH-1:0]    target;
    logic [SLOT_W-1:0] slot_w;
    logic              shed_w;

    rsc_mode_qual #(
        .QUAL_W      (QUAL_W),
        .QUAL_THRESH (QUAL_THRESH)
    ) u_qual (
        .clk          (clk),
        .rst_n        (rst_n),
        .light_load_i (light_load_i),
        .mode_nxt_o   (mode_nxt),
        .mode_o       (mode_cur)
    );

    rsc_rotor #(
        .NPH   (NPH),
        .PTR_W (PTR_W)
    ) u_rotor (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (mode_cur),
        .burst_i  (burst_i),
        .ptr_o    (ptr_w),
        .sel_oh_o (sel_oh)
    );

    always_comb begin
        if (mode_nxt == MODE_FULL) begin
            target = '1;
        end else if (burst_i) begin
            target = sel_oh;
        end else begin
            target = '0;
        end
    end

    rsc_slot_timer #(
        .NPH    (NPH),
        .PERIOD (PERIOD),
        .SLOT_W (SLOT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .target_i (target),
        .en_o     (phase_en_o),
        .pulse_o  (set_pulse_o),
        .run_o    (clk_run_o),
        .slot_o   (slot_w)
    );

    assign shed_w = (mode_cur == MODE_SHED);

endmodule

// File: rtl/rot_shed_ctrl_chk.sv
module rot_shed_ctrl_chk #(
    parameter int NPH    = 4,
    parameter int PERIOD = 4,
    parameter int PTR_W  = 2,
    parameter int SLOT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              light_load_i,
    input logic              burst_i,
    input logic [NPH-1:0]    phase_en_o,
    input logic [NPH-1:0]    set_pulse_o,
    input logic              clk_run_o,
    input logic [SLOT_W-1:0] slot,
    input logic [PTR_W-1:0]  ptr,
    input logic              shed
);

    // R5
    en_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_en_o == '1) || $onehot0(phase_en_o));

    // R3
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(set_pulse_o) && ((set_pulse_o & ~phase_en_o) == '0));

    // R7
    gated_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_run_o |-> (phase_en_o == '0));

    // R8
    en_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_en_o != $past(phase_en_o)) |->
            (!$past(clk_run_o) || ($past(slot) == SLOT_W'(PERIOD - 1))));

    // R6
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_i && $past(burst_i)) |-> $stable(ptr));

    // R6
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(burst_i) && shed) |=>
            (ptr == (($past(ptr) == PTR_W'(NPH - 1)) ? '0 : $past(ptr) + 1'b1)));

    // R9
    full_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(light_load_i) |=> !shed);

endmodule

bind rot_shed_ctrl rot_shed_ctrl_chk #(
    .NPH    (NPH),
    .PERIOD (PERIOD),
    .PTR_W  (PTR_W),
    .SLOT_W (SLOT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .light_load_i (light_load_i),
    .burst_i      (burst_i),
    .phase_en_o   (phase_en_o),
    .set_pulse_o  (set_pulse_o),
    .clk_run_o    (clk_run_o),
    .slot         (slot_w),
    .ptr          (ptr_w),
    .shed         (shed_w)
);

// File: tb/rot_shed_ctrl_tb.sv
module rot_shed_ctrl_tb;

    localparam int NPH    = 4;
    localparam int PERIOD = 4;
    localparam int THR    = 200;
    localparam int NV     = 6;
    localparam int BLEN [NV] = '{1, 6, 4, 9, 2, 13};
    localparam int BPH  [NV] = '{0, 1, 2, 3, 0, 1};

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           light = 1'b0;
    logic           burst = 1'b0;
    logic [NPH-1:0] en;
    logic [NPH-1:0] pulse;
    logic           run;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    rot_shed_ctrl #(
        .NPH         (NPH),
        .PERIOD      (PERIOD),
        .QUAL_W      (8),
        .QUAL_THRESH (THR)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .light_load_i (light),
        .burst_i      (burst),
        .phase_en_o   (en),
        .set_pulse_o  (pulse),
        .clk_run_o    (run)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic do_burst(input int len, input int ph, input string tag);
        int cnt [NPH];
        int other;
        for (int p = 0; p < NPH; p++) cnt[p] = 0;
        burst = 1'b1;
        for (int k = 0; k < len; k++) begin
            tick();
            if (k == 0) chk(en == NPH'(1 << ph), {tag, " R5 selected enable"}, int'(en), 1 << ph);
            for (int p = 0; p < NPH; p++) if (pulse[p]) cnt[p]++;
        end
        burst = 1'b0;
        for (int k = 0; k < 8; k++) begin
            tick();
            for (int p = 0; p < NPH; p++) if (pulse[p]) cnt[p]++;
        end
        other = 0;
        for (int p = 0; p < NPH; p++) if (p != ph) other += cnt[p];
        chk(cnt[ph] == (len + PERIOD - 1) / PERIOD, {tag, " R8 pulse count"}, cnt[ph], (len + PERIOD - 1) / PERIOD);
        chk(other == 0, {tag, " R6 other phases silent"}, other, 0);
        chk(en == '0 && !run, {tag, " R7 shutdown"}, {27'd0, run, en}, 0);
    endtask

    task automatic enter_shed();
        light = 1'b1;
        wait_cyc(THR + 6);
        chk(en == '0 && !run, "R4 shed entered", {27'd0, run, en}, 0);
    endtask

    initial begin
        wait_cyc(3);
        // R1 reset state
        chk(en == '0 && pulse == '0 && !run, "R1 reset outputs", {23'd0, run, pulse, en}, 0);
        rst_n = 1'b1;

        // R2 / R3 full-phase staircase
        for (int i = 0; i < 8; i++) begin
            tick();
            if (i == 0) chk(en == 4'hF && run, "R2 all enabled", {27'd0, run, en}, 5'h1F);
            chk(pulse == NPH'(1 << (i % NPH)), "R3 staggered pulse", int'(pulse), 1 << (i % NPH));
        end

        // R4 one cycle short of threshold
        light = 1'b1;
        wait_cyc(THR);
        chk(en == 4'hF, "R4 not yet qualified", int'(en), 4'hF);
        light = 1'b0;
        wait_cyc(10);
        chk(en == 4'hF && run, "R4 short run cleared", {27'd0, run, en}, 5'h1F);

        enter_shed();

        // R5 R6 R8 burst table
        for (int v = 0; v < NV; v++) begin
            do_burst(BLEN[v], BPH[v], $sformatf("vec%0d", v));
        end

        // R9 immediate return to full mode
        light = 1'b0;
        tick();
        chk(en == 4'hF && run, "R9 full-phase return", {27'd0, run, en}, 5'h1F);
        // R6 stray bursts in full mode must not rotate
        for (int k = 0; k < 3; k++) begin
            burst = 1'b1;
            wait_cyc(2);
            burst = 1'b0;
            wait_cyc(2);
        end
        enter_shed();
        // R10 pointer kept
        do_burst(3, 2, "R10 kept");

        // R10 reset clears pointer
        rst_n = 1'b0;
        wait_cyc(2);
        chk(en == '0 && !run, "R1 reset again", {27'd0, run, en}, 0);
        rst_n = 1'b1;
        enter_shed();
        do_burst(2, 0, "R10 cleared");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule